// File: doc/BRIEF.md
# Encoded-Ratio Clock Enable Generator

This block derives three clock-enable pulse trains for a processor core domain, a system-bus domain and a peripheral domain from one fast base clock. Every output is a synchronous enable in the base clock domain. No derived clock is ever produced. Logic in a slower domain advances only in the cycles where its enable is high.

A single 16-bit control word sets the three ratios. Each domain has a 3-bit code that selects its divisor from a small lookup table, so the ratios can be values such as 3 or 5 as well as powers of two. A PLL-enable bit in the same word inserts an extra divide-by-6 stage in front of all three dividers when it is cleared.

The control word sits behind a simple write and read port. Only the low 12 address bits are decoded. Each write clears every prescaler counter, so the new ratios start from a clean phase in the next cycle.

Top module: `clk_enable_gen`

## Requirements
- R1: After reset the control word reads 0x0E0A. That value gives a core enable that is always high, a bus enable that pulses once every 2 cycles and a peripheral enable that pulses once every 4 cycles.
- R2: Control bits [8:6] hold the core-domain code. Codes 0 to 7 give divisors 1, 2, 3, 4, 5, 8, 8, 8.
- R3: Control bits [5:3] hold the bus-domain code and use the same table as the core domain.
- R4: Control bits [2:0] hold the peripheral code. Codes 0 to 7 give divisors 2, 3, 4, 6, 8, 8, 8, 8.
- R5: When control bit 10 is 0, the base rate is divided by 6 before the domain dividers. Each domain's period is then 6 times its divisor.
- R6: Each enable is high for exactly one cycle per period of P cycles. When P is 1, the enable is high in every cycle.
- R7: A write restarts all counters. Number the cycles after the capturing edge k = 0, 1, 2 and so on; the domain's enable is then high exactly when (k+1) is a multiple of P. The same phase holds from the release of reset.
- R8: The read port returns the last value written, whenever the address matches. For any other address it returns 0.
- R9: Address bits above bit 11 are ignored. A write whose low 12 bits differ from the control offset (0x000) leaves the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_addr | input | 32 | Register address; only bits [11:0] are decoded |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data: the control word on an address match, else 0 |
| cpu_en | output | 1 | Core-domain clock enable |
| bus_en | output | 1 | Bus-domain clock enable |
| per_en | output | 1 | Peripheral-domain clock enable |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit control word and a pre-divide of 6. With these values every table entry is reachable in both PLL settings, so periods from 1 up to 48 cycles occur. Random control words drawn from a fixed seed are each followed by an observation window of 96 cycles, which covers two full periods of the slowest ratio. Directed cases cover the reset phase, divide-by-1, aliased upper address bits, writes to a mismatched offset and a rewrite in the middle of a period.

// File: rtl/ckgen_pkg.sv
// Package: shared widths, field positions and divisor tables for the
// clock-enable generator. Assumes divisors never exceed 8.
package ckgen_pkg;
    localparam int CTRL_W   = 16;
    localparam int CODE_W   = 3;
    localparam int DIV_W    = 4;
    localparam int PLL_BIT  = 10;
    localparam int CPU_LSB  = 6;
    localparam int BUS_LSB  = 3;
    localparam int PER_LSB  = 0;
    localparam int NUM_DOM  = 3;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h0E0A;

    // Divisor for the core and bus fields.
    function automatic logic [DIV_W-1:0] fast_div(input logic [CODE_W-1:0] code);
        return (code < 3'd5) ? DIV_W'(code) + DIV_W'(1) : DIV_W'(8);
    endfunction

    // Divisor for the peripheral field.
    function automatic logic [DIV_W-1:0] slow_div(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    return DIV_W'(2);
            3'd1:    return DIV_W'(3);
            3'd2:    return DIV_W'(4);
            3'd3:    return DIV_W'(6);
            default: return DIV_W'(8);
        endcase
    endfunction
endpackage

// File: rtl/ckgen_ctrl_reg.sv
// Control word register with address match on the low 12 bits.
// Assumes a single-cycle write strobe; reads are combinational.
module ckgen_ctrl_reg #(
    parameter int ADDR_W   = 32,
    parameter int DEC_W    = 12,
    parameter logic [DEC_W-1:0] OFFSET = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [ckgen_pkg::CTRL_W-1:0] wdata,
    output logic [ckgen_pkg::CTRL_W-1:0] rdata,
    output logic [ckgen_pkg::CTRL_W-1:0] ctrl,
    output logic                        wr_hit
);
    import ckgen_pkg::*;

    logic hit;
    // Decode: compare only the low address bits.
    always_comb hit = (addr[DEC_W-1:0] == OFFSET);

    // Write qualifier, also used to restart the dividers.
    always_comb wr_hit = wr && hit;

    // Register: load on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl <= CTRL_RESET;
        else if (wr_hit) ctrl <= wdata;
    end

    // Read mux: control word on a match, zero elsewhere.
    always_comb rdata = hit ? ctrl : '0;

    p_write_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (ctrl == $past(wdata)));
    p_miss_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit) |=> $stable(ctrl));
endmodule

// File: rtl/ckgen_prescale.sv
// Pre-divider: emits a base tick every PRE_DIV cycles, or every cycle
// when bypassed. Assumes bypass only changes together with clr.
module ckgen_prescale #(
    parameter int PRE_DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bypass,
    output logic tick
);
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    logic [PW-1:0] cnt;

    // Tick on the last count, or always when bypassed.
    always_comb tick = bypass || (cnt == PW'(PRE_DIV - 1));

    // Counter: wraps at PRE_DIV, held at zero when bypassed or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || bypass)     cnt <= '0;
        else if (cnt == PW'(PRE_DIV - 1)) cnt <= '0;
        else                             cnt <= cnt + PW'(1);
    end

    p_pre_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !bypass && !clr) |=> !tick);
endmodule

// File: rtl/ckgen_ratio.sv
// Domain divider: counts base ticks and emits one enable per div ticks.
// Assumes div >= 1 and that div only changes in a cycle with clr high.
module ckgen_ratio #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    output logic             en
);
    logic [DIV_W-1:0] cnt;

    // Enable on the tick that completes a period.
    always_comb en = tick && (cnt == div - DIV_W'(1));

    // Tick counter: restarts after each enable or a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= en ? '0 : cnt + DIV_W'(1);
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < div);
    p_pulse_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && div != DIV_W'(1) && !clr) |=> !en);
endmodule

// File: rtl/clk_enable_gen.sv
// Top: control register, shared pre-divider and three domain dividers.
// Outputs are single-cycle enables in the base clock domain.
module clk_enable_gen #(
    parameter int ADDR_W  = 32,
    parameter int PRE_DIV = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        cpu_en,
    output logic        bus_en,
    output logic        per_en
);
    import ckgen_pkg::*;

    logic [CTRL_W-1:0] ctrl;
    logic              wr_hit;
    logic              tick;
    logic [DIV_W-1:0]  div_sel [NUM_DOM];
    logic [NUM_DOM-1:0] en_vec;

    ckgen_ctrl_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr[ADDR_W-1:0]),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl), .wr_hit(wr_hit)
    );

    ckgen_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(wr_hit),
        .bypass(ctrl[PLL_BIT]), .tick(tick)
    );

    // Field decode: each domain's divisor from its table.
    always_comb begin
        div_sel[0] = fast_div(ctrl[CPU_LSB +: CODE_W]);
        div_sel[1] = fast_div(ctrl[BUS_LSB +: CODE_W]);
        div_sel[2] = slow_div(ctrl[PER_LSB +: CODE_W]);
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        ckgen_ratio #(.DIV_W(DIV_W)) u_div (
            .clk(clk), .rst_n(rst_n), .clr(wr_hit), .tick(tick),
            .div(div_sel[d]), .en(en_vec[d])
        );
    end

    // Output mapping.
    always_comb begin
        cpu_en = en_vec[0];
        bus_en = en_vec[1];
        per_en = en_vec[2];
    end

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !(reg_wdata[PLL_BIT] && reg_wdata[CPU_LSB +: CODE_W] == 3'd0))
        |=> !cpu_en);
    p_div1_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[PLL_BIT] && ctrl[CPU_LSB +: CODE_W] == 3'd0) |-> cpu_en);
    p_per_never_every_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (per_en && !wr_hit) |=> !per_en);
endmodule

// File: tb/clk_enable_gen_tb_top.sv
module clk_enable_gen_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic [31:0] reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        cpu_en, bus_en, per_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    clk_enable_gen dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_en(cpu_en), .bus_en(bus_en), .per_en(per_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int tbl_fast(input int code);
        int t[8] = '{1, 2, 3, 4, 5, 8, 8, 8};
        return t[code];
    endfunction
    function automatic int tbl_slow(input int code);
        int t[8] = '{2, 3, 4, 6, 8, 8, 8, 8};
        return t[code];
    endfunction
    // Period in base cycles for domain dom (0 core, 1 bus, 2 peripheral).
    function automatic int period(input logic [15:0] w, input int dom);
        int pre = w[10] ? 1 : 6;
        case (dom)
            0: return pre * tbl_fast(int'(w[8:6]));
            1: return pre * tbl_fast(int'(w[5:3]));
            default: return pre * tbl_slow(int'(w[2:0]));
        endcase
    endfunction

    // Observe ncyc cycles starting at phase k=0 (caller is already in k=0).
    task automatic observe(input logic [15:0] w, input int ncyc, input string tag);
        int bad = 0;
        logic [2:0] act, exp;
        for (int k = 0; k < ncyc; k++) begin
            if (k > 0) @(negedge clk);
            act = {per_en, bus_en, cpu_en};
            for (int d = 0; d < 3; d++) exp[d] = ((k + 1) % period(w, d)) == 0;
            if (act !== exp && bad == 0) begin
                $display("FAIL %s word=%h cycle %0d: enables act=%b exp=%b", tag, w, k, act, exp);
                bad++;
            end
        end
        n_chk++;
        if (bad != 0) n_fail++;
    endtask

    task automatic wr_word(input logic [31:0] a, input logic [15:0] w);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = w;
        @(negedge clk);
        reg_wr = 0; reg_addr = 0;
    endtask

    task automatic chk_read(input logic [31:0] a, input logic [15:0] exp, input string tag);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s read addr=%h act=%h exp=%h", tag, a, reg_rdata, exp);
        end
        reg_addr = 0;
        #1;
    endtask

    initial begin
        logic [15:0] w;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 / R7: phase from reset release, reset word
        observe(16'h0E0A, 24, "R1 reset pattern");
        @(negedge clk);
        chk_read(32'h0, 16'h0E0A, "R1 reset value");

        // R2 / R6: every core code with PLL on, divide-by-1 included
        for (int c = 0; c < 8; c++) begin
            w = 16'h0400 | 16'(c << 6) | 16'(((c + 3) % 8) << 3) | 16'(c);
            wr_word(32'h0, w);
            observe(w, 48, "R2 core code");
        end
        // R3 / R4: every bus and peripheral code
        for (int c = 0; c < 8; c++) begin
            w = 16'h0400 | 16'(c << 3) | 16'((7 - c));
            wr_word(32'h0, w);
            observe(w, 48, "R3 R4 bus/peripheral code");
        end
        // R5: PLL bit cleared, extra divide by 6
        w = 16'h0000;
        wr_word(32'h0, w);
        observe(w, 60, "R5 pll off minimum");
        w = 16'h0017;
        wr_word(32'h0, w);
        observe(w, 96, "R5 pll off mixed");
        // R7: rewrite mid-period restarts phase
        w = 16'h0424;
        wr_word(32'h0, w);
        repeat (3) @(negedge clk);
        wr_word(32'h0, w);
        observe(w, 40, "R7 mid-period rewrite");
        // R9: upper address bits aliased
        w = 16'h0452;
        wr_word(32'hABCD_F000, w);
        observe(w, 32, "R9 aliased write");
        chk_read(32'h1234_5000, w, "R9 aliased read");
        // R9 / R8: write to other offset ignored, other offset reads 0
        wr_word(32'h0000_0004, 16'h0001);
        chk_read(32'h0, w, "R9 mismatched write ignored");
        chk_read(32'h0000_0008, 16'h0000, "R8 mismatched read");
        // Random words
        for (int i = 0; i < 30; i++) begin
            w = 16'($urandom) & 16'h07FF;
            wr_word(32'h0, w);
            observe(w, 96, "R6 R7 random");
            @(negedge clk);
            chk_read(32'h0, w, "R8 readback");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule